// File: doc/BRIEF.md
# Multi-Port Cell Transmit Scheduler

This block sits on the cell-layer side of a byte-wide transmit link that feeds up to four physical-layer ports. Every port drives its own ready line, which says whether it can take one more complete cell. The scheduler looks at those ready lines together with a per-port "cell waiting" flag from an upstream cell store. It picks a port in round-robin order, presents that port's address while the transmit enable is inactive, and then streams one fixed-length cell. A start-of-cell strobe marks the first byte of every cell.

The upstream cell store is read through a simple request port. Each cycle the scheduler names a port and a byte index, and the store returns that byte combinationally. The scheduler registers the byte onto the data bus, so the byte appears one cycle after it is requested. A one-cycle pulse in the address-select cycle tells the store that a cell from the named port has been committed, so the store can lower that port's waiting flag.

Top module: `cell_tx_sched`

## Requirements
- R1: A cell is committed to a port only if, in the cycle the choice is made, that port's ready line and its waiting flag are both high.
- R2: The address bus carries the port index, which is the port number minus one (port 1 is 0, port 4 is 3). The address stays constant for the whole of a cell.
- R3: Before every cell there is at least one cycle with the enable high (inactive) and the new address already on the bus. When the block is idle, the address appears on the cycle after the eligibility is seen.
- R4: On the cycle after the address-select cycle, the enable goes low (active), the strobe goes high and the data bus carries byte 0 of the cell.
- R5: The start-of-cell strobe is high for the first byte only, and never at any other time.
- R6: A cell is 52 consecutive enabled bytes (4 header bytes, then 48 payload bytes). Byte k on the bus is the value the store returned for index k of that port. The enable rises right after byte 51.
- R7: If a ready line drops during a cell, that cell still completes in full, and no further cell goes to that port until its ready line is high again.
- R8: Whenever the enable is high, the data bus and the strobe are both zero.
- R9: The port search starts at the port after the one most recently served and wraps past port 4 to port 1. After reset the search starts at port 1.
- R10: When another eligible port exists at the end of a cell, the next cell's address-select cycle follows the last byte immediately, so the enable is high for exactly one cycle between the two cells.
- R11: A synchronous active-high reset, even in the middle of a cell, leaves the block idle on the next cycle: enable high, strobe low, data zero, address zero.
- R12: The store request names the port and byte index in the cycle before that byte is due on the bus. The commit pulse is high exactly in the address-select cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| port_avail | input | NUM_PORTS | Per-port ready line from the physical ports |
| cell_pend | input | NUM_PORTS | Per-port cell-waiting flag from the cell store |
| rd_port | output | $clog2(NUM_PORTS) | Port whose byte is requested from the store |
| rd_idx | output | $clog2(CELL_BYTES+1) | Index of the requested byte within the cell |
| cell_start | output | 1 | Commit pulse for the cell of rd_port (address-select cycle) |
| src_byte | input | DATA_W | Byte returned by the store for rd_port/rd_idx |
| tx_addr | output | ADDR_W | Port address bus |
| tx_en_n | output | 1 | Transmit enable, active low |
| tx_data | output | DATA_W | Transmit data byte |
| tx_soc | output | 1 | Start-of-cell strobe |

## Verification
The first results of a decision are due in fixed cycles. Eligibility seen at clock edge c puts the address out after edge c, and the first byte with its strobe after edge c+1. Each later byte follows one edge after the previous one, and after the last byte the enable is high for exactly one sampled cycle when more work is waiting. The bench samples every output on the falling edge and tracks each cell byte by byte against these offsets: the address-select cycle, then index 0 with the strobe, then index k on the k-th enabled cycle. A reset is checked on the first falling edge after the edge that took it.

// File: rtl/cts_pkg.sv
package cts_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEL  = 2'd1,
        ST_XFER = 2'd2
    } cts_state_e;

endpackage

// File: rtl/cts_rr_pick.sv
// Round-robin pick: lowest offset from start among the set request bits.
module cts_rr_pick #(
    parameter  int N  = 4,
    localparam int PW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [PW-1:0] start,
    output logic          found,
    output logic [PW-1:0] pick
);

    always_comb begin
        int idx;
        found = |req;
        pick  = '0;
        // Walk from the farthest offset down so the nearest request wins.
        for (int off = N - 1; off >= 0; off--) begin
            idx = int'(start) + off;
            if (idx >= N) begin
                idx = idx - N;
            end
            if (req[idx]) begin
                pick = PW'(idx);
            end
        end
    end

endmodule

// File: rtl/cts_beat.sv
// Byte position helper for one cell.
module cts_beat #(
    parameter  int CELL_BYTES = 52,
    localparam int CW         = $clog2(CELL_BYTES + 1)
) (
    input  logic [CW-1:0] cnt,
    output logic          is_last,
    output logic [CW-1:0] cnt_inc
);

    assign is_last = (cnt == CW'(CELL_BYTES - 1));
    assign cnt_inc = cnt + CW'(1);

endmodule

// File: rtl/cell_tx_sched.sv
module cell_tx_sched
    import cts_pkg::*;
#(
    parameter  int NUM_PORTS  = 4,
    parameter  int DATA_W     = 8,
    parameter  int ADDR_W     = 8,
    parameter  int CELL_BYTES = 52,
    localparam int PW         = $clog2(NUM_PORTS),
    localparam int CW         = $clog2(CELL_BYTES + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_PORTS-1:0] port_avail,
    input  logic [NUM_PORTS-1:0] cell_pend,
    output logic [PW-1:0]        rd_port,
    output logic [CW-1:0]        rd_idx,
    output logic                 cell_start,
    input  logic [DATA_W-1:0]    src_byte,
    output logic [ADDR_W-1:0]    tx_addr,
    output logic                 tx_en_n,
    output logic [DATA_W-1:0]    tx_data,
    output logic                 tx_soc
);

    typedef struct packed {
        cts_state_e        state;
        logic [PW-1:0]     port;
        logic [PW-1:0]     ptr;
        logic [CW-1:0]     cnt;
        logic              en_n;
        logic              soc;
        logic [DATA_W-1:0] data;
    } regs_t;

    localparam regs_t REGS_RST = '{
        state: ST_IDLE,
        port:  '0,
        ptr:   '0,
        cnt:   '0,
        en_n:  1'b1,
        soc:   1'b0,
        data:  '0
    };

    regs_t r_q, r_d;

    logic [NUM_PORTS-1:0] elig;
    logic                 found;
    logic [PW-1:0]        pick;
    logic [PW-1:0]        ptr_after;
    logic                 is_last;
    logic [CW-1:0]        cnt_inc;

    assign elig = port_avail & cell_pend;

    cts_rr_pick #(
        .N(NUM_PORTS)
    ) i_pick (
        .req   (elig),
        .start (r_q.ptr),
        .found (found),
        .pick  (pick)
    );

    cts_beat #(
        .CELL_BYTES(CELL_BYTES)
    ) i_beat (
        .cnt     (r_q.cnt),
        .is_last (is_last),
        .cnt_inc (cnt_inc)
    );

    assign ptr_after = (pick == PW'(NUM_PORTS - 1)) ? '0 : pick + PW'(1);

    always_comb begin
        r_d      = r_q;
        r_d.en_n = 1'b1;
        r_d.soc  = 1'b0;
        r_d.data = '0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (found) begin
                    r_d.state = ST_SEL;
                    r_d.port  = pick;
                    r_d.ptr   = ptr_after;
                end
            end
            ST_SEL: begin
                r_d.state = ST_XFER;
                r_d.cnt   = '0;
                r_d.en_n  = 1'b0;
                r_d.soc   = 1'b1;
                r_d.data  = src_byte;
            end
            ST_XFER: begin
                if (is_last) begin
                    if (found) begin
                        r_d.state = ST_SEL;
                        r_d.port  = pick;
                        r_d.ptr   = ptr_after;
                    end else begin
                        r_d.state = ST_IDLE;
                    end
                end else begin
                    r_d.cnt  = cnt_inc;
                    r_d.en_n = 1'b0;
                    r_d.data = src_byte;
                end
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase
        if (rst) begin
            r_d = REGS_RST;
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign rd_port    = r_q.port;
    assign rd_idx     = (r_q.state == ST_SEL) ? '0 : cnt_inc;
    assign cell_start = (r_q.state == ST_SEL);
    assign tx_addr    = ADDR_W'(r_q.port);
    assign tx_en_n    = r_q.en_n;
    assign tx_data    = r_q.data;
    assign tx_soc     = r_q.soc;

endmodule

// File: rtl/cts_checks.sv
module cts_checks #(
    parameter  int NUM_PORTS  = 4,
    parameter  int DATA_W     = 8,
    parameter  int ADDR_W     = 8,
    parameter  int CELL_BYTES = 52,
    localparam int PW         = $clog2(NUM_PORTS),
    localparam int CW         = $clog2(CELL_BYTES + 1)
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_PORTS-1:0] port_avail,
    input logic [NUM_PORTS-1:0] cell_pend,
    input logic                 cell_start,
    input logic [ADDR_W-1:0]    tx_addr,
    input logic                 tx_en_n,
    input logic [DATA_W-1:0]    tx_data,
    input logic                 tx_soc
);

    logic [NUM_PORTS-1:0] elig_q;
    logic [CW-1:0]        run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            elig_q <= '0;
            run_q  <= '0;
        end else begin
            elig_q <= port_avail & cell_pend;
            run_q  <= tx_en_n ? '0 : run_q + CW'(1);
        end
    end

    AST_START_ELIGIBLE: assert property (@(posedge clk) disable iff (rst)
        cell_start |-> elig_q[tx_addr[PW-1:0]]); // R1

    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (rst)
        tx_addr < ADDR_W'(NUM_PORTS)); // R2

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        !tx_en_n |-> $stable(tx_addr)); // R2

    AST_SETUP_BEFORE_SOC: assert property (@(posedge clk) disable iff (rst)
        tx_soc |-> (!tx_en_n && $past(tx_en_n))); // R3

    AST_SOC_FIRST_ONLY: assert property (@(posedge clk) disable iff (rst)
        tx_soc |-> (run_q == '0)); // R5

    AST_ENABLE_STARTS_WITH_SOC: assert property (@(posedge clk) disable iff (rst)
        (!tx_en_n && run_q == '0) |-> tx_soc); // R4

    AST_CELL_LENGTH: assert property (@(posedge clk) disable iff (rst)
        (tx_en_n && run_q != '0) |-> (run_q == CW'(CELL_BYTES))); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        tx_en_n |-> (tx_data == '0 && !tx_soc)); // R8

    AST_START_WHILE_OFF: assert property (@(posedge clk) disable iff (rst)
        cell_start |-> tx_en_n); // R12

endmodule

bind cell_tx_sched cts_checks #(
    .NUM_PORTS  (NUM_PORTS),
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .CELL_BYTES (CELL_BYTES)
) i_cts_checks (
    .clk        (clk),
    .rst        (rst),
    .port_avail (port_avail),
    .cell_pend  (cell_pend),
    .cell_start (cell_start),
    .tx_addr    (tx_addr),
    .tx_en_n    (tx_en_n),
    .tx_data    (tx_data),
    .tx_soc     (tx_soc)
);

// File: tb/test_cell_tx_sched.sv
`timescale 1ns/1ps
module test_cell_tx_sched;

    localparam int NP = 4;
    localparam int DW = 8;
    localparam int AW = 8;
    localparam int CB = 52;
    localparam int PW = 2;
    localparam int CW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NP-1:0] avail = '0;
    logic [NP-1:0] pend;
    logic [PW-1:0] rd_port;
    logic [CW-1:0] rd_idx;
    logic          cell_start;
    logic [DW-1:0] src_byte;
    logic [AW-1:0] tx_addr;
    logic          tx_en_n;
    logic [DW-1:0] tx_data;
    logic          tx_soc;

    int pend_cnt [NP];
    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    cell_tx_sched #(
        .NUM_PORTS(NP), .DATA_W(DW), .ADDR_W(AW), .CELL_BYTES(CB)
    ) i_cell_tx_sched (
        .clk(clk), .rst(rst), .port_avail(avail), .cell_pend(pend),
        .rd_port(rd_port), .rd_idx(rd_idx), .cell_start(cell_start),
        .src_byte(src_byte), .tx_addr(tx_addr), .tx_en_n(tx_en_n),
        .tx_data(tx_data), .tx_soc(tx_soc)
    );

    // Cell store model: byte value = port * 64 + index.
    for (genvar g = 0; g < NP; g++) begin : g_pend
        assign pend[g] = (pend_cnt[g] != 0);
    end
    assign src_byte = {rd_port, rd_idx};

    always @(negedge clk) begin
        if (!rst && cell_start) begin
            pend_cnt[rd_port] = pend_cnt[rd_port] - 1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Output monitor, sampled on the falling edge.
    bit          prev_en_n = 1'b1;
    logic [AW-1:0] prev_addr = '0;
    bit          in_cell = 1'b0;
    int          k = 0;
    int          cur = 0;
    int          gap = 0;
    bit          b2b_mode = 1'b0;
    bit          first_cell = 1'b1;
    int          got [$];

    always @(negedge clk) begin
        if (rst) begin
            in_cell   = 1'b0;
            prev_en_n = 1'b1;
            gap       = 0;
        end else begin
            if (tx_en_n) begin
                check(tx_data == '0 && !tx_soc, "R8", "idle bus quiet", int'(tx_data), 0);
                if (in_cell) begin
                    check(k == CB - 1, "R6", "cell length", k + 1, CB);
                    in_cell = 1'b0;
                    gap     = 0;
                end
                gap++;
            end else if (tx_soc) begin
                check(prev_en_n, "R3", "enable high before start", int'(prev_en_n), 1);
                check(tx_addr == prev_addr, "R3", "address set up early",
                      int'(tx_addr), int'(prev_addr));
                check(tx_addr < NP, "R2", "address range", int'(tx_addr), NP - 1);
                check(!in_cell, "R5", "strobe inside a cell", k, 0);
                if (b2b_mode && !first_cell) begin
                    check(gap == 1, "R10", "gap between cells", gap, 1);
                end
                first_cell = 1'b0;
                in_cell    = 1'b1;
                k          = 0;
                cur        = int'(tx_addr);
                got.push_back(cur);
                check(int'(tx_data) == cur * 64, "R4", "first byte", int'(tx_data), cur * 64);
            end else begin
                if (!in_cell) begin
                    check(1'b0, "R4", "enabled byte without start strobe", 0, 1);
                end else begin
                    k++;
                    check(int'(tx_data) == cur * 64 + k, "R6", "cell byte",
                          int'(tx_data), cur * 64 + k);
                    check(int'(tx_addr) == cur, "R2", "address held", int'(tx_addr), cur);
                    check(k < CB, "R6", "cell overrun", k, CB - 1);
                end
            end
            prev_en_n = tx_en_n;
            prev_addr = tx_addr;
        end
    end

    task automatic expect_order(input string req, input int exp [$]);
        check(got.size() == exp.size(), req, "cell count", got.size(), exp.size());
        foreach (exp[i]) begin
            if (i < got.size()) begin
                check(got[i] == exp[i], req, "port order", got[i], exp[i]);
            end
        end
    endtask

    task automatic idle_wait(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        foreach (pend_cnt[i]) pend_cnt[i] = 0;
        repeat (3) @(negedge clk);
        // R11: state held in reset
        check(tx_en_n == 1'b1, "R11", "reset enable", int'(tx_en_n), 1);
        check(tx_soc == 1'b0, "R11", "reset strobe", int'(tx_soc), 0);
        check(tx_data == '0, "R11", "reset data", int'(tx_data), 0);
        check(tx_addr == '0, "R11", "reset address", int'(tx_addr), 0);
        check(cell_start == 1'b0, "R12", "reset commit pulse", int'(cell_start), 0);
        rst = 1'b0;

        // R9 / R10: all ports ready, one cell each, pointer at port 1
        b2b_mode = 1'b1; first_cell = 1'b1; got.delete();
        foreach (pend_cnt[i]) pend_cnt[i] = 1;
        avail = 4'hF;
        // R3: idle latency, address one cycle after eligibility
        @(negedge clk);
        check(tx_en_n && tx_addr == 0 && cell_start, "R3", "address after one cycle",
              int'(tx_addr), 0);
        @(negedge clk);
        check(!tx_en_n && tx_soc, "R4", "first byte one cycle later", int'(tx_soc), 1);
        idle_wait(4 * (CB + 1) + 10);
        expect_order("R9", '{0, 1, 2, 3});

        // R10: two ports alternate with no extra idle cycles
        first_cell = 1'b1; got.delete();
        pend_cnt[1] = 2; pend_cnt[3] = 2;
        idle_wait(4 * (CB + 1) + 10);
        expect_order("R10", '{1, 3, 1, 3});

        // R1: waiting cell on a port that is not ready is not sent
        b2b_mode = 1'b0; got.delete();
        avail = 4'b0100;
        pend_cnt[0] = 1; pend_cnt[2] = 1;
        idle_wait(2 * (CB + 1) + 10);
        expect_order("R1", '{2});
        avail = 4'b0101;
        idle_wait(CB + 10);
        expect_order("R1", '{2, 0});

        // R7: ready line drops mid-cell
        got.delete();
        avail = 4'b0010;
        pend_cnt[1] = 2;
        wait (in_cell && k == 10);
        @(negedge clk);
        avail = 4'b0000;
        idle_wait(CB + 60);
        expect_order("R7", '{1});
        check(pend_cnt[1] == 1, "R7", "second cell still waiting", pend_cnt[1], 1);
        avail = 4'b0010;
        idle_wait(CB + 10);
        expect_order("R7", '{1, 1});

        // R9: search resumes after last served port (port index 1 -> start at 2)
        b2b_mode = 1'b1; first_cell = 1'b1; got.delete();
        avail = 4'hF;
        pend_cnt[0] = 3; pend_cnt[2] = 1;
        idle_wait(4 * (CB + 1) + 10);
        expect_order("R9", '{2, 0, 0, 0});

        // R11: reset in the middle of a cell, pointer back to port 1
        b2b_mode = 1'b0;
        pend_cnt[3] = 1;
        wait (in_cell && k == 5);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(tx_en_n == 1'b1 && tx_soc == 1'b0, "R11", "mid-cell reset enable",
              int'(tx_en_n), 1);
        check(tx_data == '0 && tx_addr == '0, "R11", "mid-cell reset bus",
              int'(tx_data), 0);
        got.delete();
        pend_cnt[1] = 1; pend_cnt[3] = 1;
        rst = 1'b0;
        idle_wait(2 * (CB + 1) + 20);
        expect_order("R11", '{1, 3});

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule